// File: doc/BRIEF.md
# Crosspoint Switch Control Store

This block holds the on/off state of every crosspoint in a matrix of 12 rows by 8 columns. A host selects one crosspoint with a 4-bit row code and a 3-bit column code, presents one data bit and raises a strobe. While the strobe is high, the selected cell takes the data bit on every clock cycle, so it behaves like a transparent latch at clock resolution. After the strobe falls, the cell keeps the last value it took. Every other cell keeps its state.

The row decoder is sparse. Row codes 0 to 5 reach rows 0 to 5, and row codes 8 to 13 reach rows 6 to 11. Codes 6, 7, 14 and 15 reach no row, and a write to one of them does nothing. An active-high reset clears every cell at once without waiting for a clock edge, which opens every crosspoint. The 96 cell states leave the block as a flat vector that drives the switch matrix.

Top module: `xpt_ctrl_store`

## Requirements
- R1: When rst rises, every bit of sw_en becomes 0 at once, without waiting for a clock edge. All bits stay 0 while rst is high.
- R2: While rst is high, a strobe write has no effect: sw_en stays all zero.
- R3: Row codes 0 to 5 select rows 0 to 5. Column code c selects column c. The cell for row r and column c is sw_en[r*8 + c].
- R4: Row codes 8 to 13 select rows 6 to 11, in that order (code 8 selects row 6, code 13 selects row 11).
- R5: A strobe write with row code 6, 7, 14 or 15 leaves all 96 bits of sw_en unchanged, whatever the column code and data.
- R6: At each rising clock edge where strobe is high, rst is low and the row code is valid, the addressed bit takes data_in. The new value shows on sw_en after that edge. When data_in toggles across successive cycles of one strobe, the bit follows it.
- R7: At an edge where strobe is low, sw_en does not change. The addressed bit therefore keeps the value it took at the last strobe-high edge, and later changes to data_in or the address have no effect.
- R8: A write changes only the addressed bit. The other 95 bits keep their values.
- R9: Writing 0 to a bit that holds 1 clears that bit, and the crosspoint opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the inputs are sampled on its rising edge |
| rst | input | 1 | Active-high reset that clears every cell asynchronously |
| strobe | input | 1 | Write enable; while it is high the addressed cell takes data_in |
| row_addr | input | 4 | Row code; 0-5 select rows 0-5, 8-13 select rows 6-11, other codes select nothing |
| col_addr | input | 3 | Column code; selects columns 0-7 directly |
| data_in | input | 1 | Value written to the addressed cell (1 closes the switch, 0 opens it) |
| sw_en | output | 96 | Switch enables, with bit row*8+col for each crosspoint |

## Verification
The bench writes every one of the 96 crosspoints in turn and compares the whole vector each time. A decoder that mapped codes 8 to 13 onto the wrong rows, or an index built as col*12+row, would light the wrong bit. It writes through all four unused row codes, each with every column and both data values, over a nonzero pattern. A decoder that wrapped those codes onto real rows would change a bit there. It toggles data during one long strobe and then changes data and address after the strobe falls, which catches a cell that is edge-written on strobe or one that stays transparent. It also raises reset between clock edges and together with strobe, which exposes a synchronous clear or a write that wins over reset.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int ROW_AW    = 4;
  localparam int COL_AW    = 3;
  localparam int HALF_ROWS = 6;
  localparam int ROWS      = 2 * HALF_ROWS;
  localparam int COLS      = 1 << COL_AW;
  localparam int CELLS     = ROWS * COLS;
endpackage

// File: rtl/xpt_row_decode.sv
module xpt_row_decode #(
  parameter int ROW_AW    = xpt_pkg::ROW_AW,
  parameter int HALF_ROWS = xpt_pkg::HALF_ROWS,
  localparam int ROWS     = 2 * HALF_ROWS,
  localparam int OFF_W    = ROW_AW - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ROW_AW-1:0] code,
  output logic [ROWS-1:0]   row_sel,
  output logic              row_valid
);
  // The top code bit picks a half; the remaining bits index inside it.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int HALF = r / HALF_ROWS;
    localparam int OFF  = r % HALF_ROWS;
    localparam logic [ROW_AW-1:0] MATCH = ROW_AW'((HALF << OFF_W) + OFF);
    assign row_sel[r] = (code == MATCH);
  end

  assign row_valid = (code[OFF_W-1:0] < OFF_W'(HALF_ROWS));

  // R5: a code outside both halves reaches no row
  p_unused_code_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (code[OFF_W-1:0] >= OFF_W'(HALF_ROWS)) |-> (row_sel == '0));
  // R3/R4: a code inside a half selects exactly one row
  p_valid_code_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    (code[OFF_W-1:0] < OFF_W'(HALF_ROWS)) |-> $onehot(row_sel));
endmodule

// File: rtl/xpt_col_decode.sv
module xpt_col_decode #(
  parameter int COL_AW = xpt_pkg::COL_AW,
  localparam int COLS  = 1 << COL_AW
) (
  input  logic [COL_AW-1:0] code,
  output logic [COLS-1:0]   col_sel
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_sel[c] = (code == COL_AW'(c));
  end
endmodule

// File: rtl/xpt_cell_array.sv
module xpt_cell_array #(
  parameter int ROWS  = xpt_pkg::ROWS,
  parameter int COLS  = xpt_pkg::COLS,
  localparam int CELLS = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             data_in,
  input  logic [ROWS-1:0]  row_sel,
  input  logic [COLS-1:0]  col_sel,
  output logic [CELLS-1:0] we,
  output logic [CELLS-1:0] cells
);
  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      localparam int IDX = r * COLS + c;
      assign we[IDX] = strobe & row_sel[r] & col_sel[c];
      always_ff @(posedge clk or posedge rst) begin
        if (rst)          cells[IDX] <= 1'b0;
        else if (we[IDX]) cells[IDX] <= data_in;
      end
    end
  end

  // R8: at most one cell is enabled in any cycle
  p_single_write_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we));
endmodule

// File: rtl/xpt_ctrl_store.sv
module xpt_ctrl_store #(
  parameter int ROW_AW    = xpt_pkg::ROW_AW,
  parameter int COL_AW    = xpt_pkg::COL_AW,
  parameter int HALF_ROWS = xpt_pkg::HALF_ROWS,
  localparam int ROWS     = 2 * HALF_ROWS,
  localparam int COLS     = 1 << COL_AW,
  localparam int CELLS    = ROWS * COLS,
  localparam int IDX_W    = $clog2(CELLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [ROW_AW-1:0] row_addr,
  input  logic [COL_AW-1:0] col_addr,
  input  logic              data_in,
  output logic [CELLS-1:0]  sw_en
);
  logic [ROWS-1:0]  row_sel;
  logic [COLS-1:0]  col_sel;
  logic             row_valid;
  logic [CELLS-1:0] we;

  xpt_row_decode #(.ROW_AW(ROW_AW), .HALF_ROWS(HALF_ROWS)) u_row (
    .clk(clk), .rst(rst), .code(row_addr),
    .row_sel(row_sel), .row_valid(row_valid)
  );

  xpt_col_decode #(.COL_AW(COL_AW)) u_col (
    .code(col_addr), .col_sel(col_sel)
  );

  xpt_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_cells (
    .clk(clk), .rst(rst), .strobe(strobe), .data_in(data_in),
    .row_sel(row_sel), .col_sel(col_sel), .we(we), .cells(sw_en)
  );

  // Checker: the flat index of the addressed cell is worked out from the
  // address fields, separately from the decoders.
  localparam int OFF_W = ROW_AW - 1;
  logic [IDX_W-1:0] chk_idx;
  logic             chk_d;
  logic             chk_v;
  logic [IDX_W-1:0] addr_idx;
  always_comb begin
    addr_idx = IDX_W'((int'(row_addr[ROW_AW-1]) * HALF_ROWS
               + int'(row_addr[OFF_W-1:0])) * COLS + int'(col_addr));
  end
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      chk_v   <= 1'b0;
      chk_idx <= '0;
      chk_d   <= 1'b0;
    end else begin
      chk_v   <= strobe & row_valid;
      chk_idx <= addr_idx;
      chk_d   <= data_in;
    end
  end

  // R6: the addressed cell shows the written value after the edge
  p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
    chk_v |-> (sw_en[chk_idx] == chk_d));
  // R7: without strobe the vector holds
  p_hold_no_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(sw_en));
  // R5: a write to an unused row code changes nothing
  p_unused_no_change_r5: assert property (@(posedge clk) disable iff (rst)
    (strobe && !row_valid) |=> $stable(sw_en));
  // R1: reset keeps every enable cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |-> (sw_en == '0));
endmodule

// File: tb/test_xpt_ctrl_store.sv
module test_xpt_ctrl_store;
  localparam int PERIOD = 10;
  localparam int CELLS  = 96;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe = 1'b0;
  logic [3:0]  row_addr = '0;
  logic [2:0]  col_addr = '0;
  logic        data_in = 1'b0;
  logic [95:0] sw_en;
  logic [95:0] exp_v = '0;
  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  xpt_ctrl_store i_xpt_ctrl_store (
    .clk(clk), .rst(rst), .strobe(strobe), .row_addr(row_addr),
    .col_addr(col_addr), .data_in(data_in), .sw_en(sw_en)
  );

  function automatic int row_of(input int code);
    if (code < 6) return code;
    if (code >= 8 && code < 14) return code - 2;
    return -1;
  endfunction

  task automatic check(input string req);
    checks++;
    if (sw_en !== exp_v) begin
      fails++;
      $display("FAIL %s: sw_en=%h expected=%h", req, sw_en, exp_v);
    end
  endtask

  // One strobe cycle: drive at negedge, the posedge samples, check at next negedge.
  task automatic wr(input int code, input int col, input logic d);
    row_addr = 4'(code); col_addr = 3'(col); data_in = d; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    if (row_of(code) >= 0) exp_v[row_of(code)*8 + col] = d;
  endtask

  task automatic t_reset_state();
    @(negedge clk); check("R1 reset state");
    rst = 1'b0; @(negedge clk); check("R1 after release");
  endtask

  task automatic t_low_rows();
    for (int code = 0; code < 6; code++)
      for (int c = 0; c < 8; c++) begin
        wr(code, c, 1'b1); check("R3 low row write");
      end
  endtask

  task automatic t_high_rows();
    for (int code = 8; code < 14; code++)
      for (int c = 0; c < 8; c++) begin
        wr(code, c, 1'b1); check("R4 high row write");
      end
  endtask

  task automatic t_clear_and_isolate();
    wr(9, 5, 1'b0); check("R9 clear one bit");
    wr(0, 0, 1'b0); check("R8 only addressed bit");
    wr(13, 7, 1'b0); check("R9 clear last cell");
  endtask

  task automatic t_unused_codes();
    int bad[4] = '{6, 7, 14, 15};
    foreach (bad[i])
      for (int c = 0; c < 8; c++) begin
        wr(bad[i], c, 1'b1); check("R5 unused code write 1");
        wr(bad[i], c, 1'b0); check("R5 unused code write 0");
      end
  endtask

  task automatic t_follow_and_hold();
    row_addr = 4'd2; col_addr = 3'd3; strobe = 1'b1;
    for (int k = 0; k < 4; k++) begin
      data_in = k[0];
      @(negedge clk);
      exp_v[2*8+3] = k[0];
      check("R6 follow data during strobe");
    end
    data_in = 1'b1; @(negedge clk); exp_v[19] = 1'b1;
    strobe = 1'b0; data_in = 1'b0; row_addr = 4'd3;
    @(negedge clk); check("R7 hold after strobe falls");
    data_in = 1'b1; @(negedge clk); check("R7 data ignored without strobe");
  endtask

  task automatic t_reset_wins();
    #(PERIOD/4) rst = 1'b1;
    #1 exp_v = '0; check("R1 asynchronous clear");
    @(negedge clk);
    wr(1, 1, 1'b1); exp_v = '0; check("R2 reset beats strobe");
    rst = 1'b0; @(negedge clk); check("R2 zero after release");
    wr(10, 4, 1'b1); check("R6 write after reset");
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: expired, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_low_rows();
    t_high_rows();
    t_clear_and_isolate();
    t_unused_codes();
    t_follow_and_hold();
    t_reset_wins();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule